// File: doc/BRIEF.md
# Interleaved Event Frame Serializer

This block gathers event records from several front-end sources and turns each record into a framed word stream. On a per-source strobe it captures a record into that source's small buffer. A record holds a bank of channel samples and the bunch-crossing and trigger identifiers of that event. Each buffer can absorb a burst of events, so it also acts as a derandomizer.

A single sequencer drains the sources one at a time, in round-robin order. Only one source ever streams, which avoids every front end driving at the same moment. Each frame has the following parts, in this order:

- a header;
- 32 data lines, sent in a stride-interleaved channel order;
- a trailer holding the column parity of all the data lines;
- two all-zero separator words.

The output uses a valid/ready handshake. A word moves only in a cycle where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. Back-pressure stalls every word of the frame, separators included. The block never withdraws a word once it has offered it.

Top module: `ilv_frame_ser`

## Requirements
- R1: The header word is `{par, src[2:0], 1'b1, 3'b000, bx[11:0], trig[11:0]}`. Here `src` is the source number and `par` makes the whole 32-bit word even parity. The header is the first word of every frame.
- R2: Data line i (i = 1..32) carries the sample of channel 4·((i−1) mod 8) + ⌊(i−1)/8⌋. Channel c of source s sits at bits `(s*32+c)*12 +: 12` of `cap_smp`.
- R3: Each data line is `{16'b0, par, src[2:0], sample[11:0]}`, where `par` gives the word even parity.
- R4: The word after line 32 is the trailer, `{16'b0, col}`. Each bit of `col` is the XOR of the same bit across all 32 data lines of the frame.
- R5: Each trailer is followed by exactly two all-zero words.
- R6: A frame starts only for a source holding at least one event. The next source is picked only after the second separator, searching round-robin from the source after the last one served. After reset the search starts at source 0.
- R7: Each source buffers up to 16 events and loses none while not full. `src_full[s]` is high when 16 events are held. A strobe to a full source is ignored.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged on the next cycle.
- R9: After reset, `out_valid` is low and every `src_full` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_stb | input | 8 | Per-source capture strobe |
| cap_bx | input | 96 | Per-source bunch-crossing identifier, 12 bits each |
| cap_trig | input | 96 | Per-source trigger identifier, 12 bits each |
| cap_smp | input | 3072 | Per-source bank of 32 samples, 12 bits each |
| src_full | output | 8 | Per-source buffer full flag |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Output word |

## Verification
The assertions assume that `out_ready` may change in any cycle. They also assume that strobes reach full sources only when a drop is intended. The stimulus drives `out_ready` from a pseudo-random pattern in stalled frames, so that the hold property is exercised mid-frame and across separators. It strobes a full source only in the one directed overflow case. Capture fields change only at negative edges, so each strobe latches one stable record.

// File: rtl/ilv_frame_pkg.sv
package ilv_frame_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_TRL, S_SEP
  } seq_state_t;

  // Channel placed on zero-based line j: groups*(j mod stride) + j/stride
  function automatic int chan_of(input int j, input int stride, input int groups);
    return groups * (j % stride) + j / stride;
  endfunction
endpackage

// File: rtl/ilv_evt_fifo.sv
module ilv_evt_fifo #(
  parameter int ENT_W = 408,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_data,
  input  logic             pop,
  output logic [ENT_W-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the sequencer never releases an event that is not there
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R7: a full buffer keeps its contents when a strobe arrives without a pop
  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/ilv_rr_pick.sv
module ilv_rr_pick #(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0]         req,
  input  logic [$clog2(NSRC)-1:0] last,
  output logic [$clog2(NSRC)-1:0] pick
);
  localparam int SRC_W = $clog2(NSRC);

  always_comb begin
    int t;
    pick = last;
    // Scan from farthest to nearest so the nearest requester wins
    for (int k = NSRC - 1; k >= 0; k--) begin
      t = (int'(last) + 1 + k) % NSRC;
      if (req[t]) pick = SRC_W'(t);
    end
  end
endmodule

// File: rtl/ilv_frame_ser.sv
module ilv_frame_ser
  import ilv_frame_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int NCH    = 32,
  parameter int STRIDE = 8,
  parameter int SAMP_W = 12,
  parameter int ID_W   = 12,
  parameter int DEPTH  = 16,
  parameter int OUT_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            cap_stb,
  input  logic [NSRC*ID_W-1:0]       cap_bx,
  input  logic [NSRC*ID_W-1:0]       cap_trig,
  input  logic [NSRC*NCH*SAMP_W-1:0] cap_smp,
  output logic [NSRC-1:0]            src_full,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [OUT_W-1:0]           out_data
);
  localparam int SRC_W  = $clog2(NSRC);
  localparam int IDX_W  = $clog2(NCH);
  localparam int GROUPS = NCH / STRIDE;
  localparam int LINE_W = 1 + SRC_W + SAMP_W;
  localparam int BANK_W = NCH * SAMP_W;
  localparam int ENT_W  = 2 * ID_W + BANK_W;
  localparam int HPAD   = OUT_W - 2 - SRC_W - 2 * ID_W;

  seq_state_t       state;
  logic [SRC_W-1:0] grant, pick;
  logic [IDX_W-1:0] idx;
  logic             sep_second;
  logic             fire;
  logic [NSRC-1:0]  empty;
  logic [ENT_W-1:0] heads [NSRC];
  logic [ENT_W-1:0] cur;

  assign fire = out_valid && out_ready;

  // One derandomizing buffer per source
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic push_s, pop_s;
    assign push_s = cap_stb[s];
    assign pop_s  = fire && (state == S_TRL) && (grant == SRC_W'(s));
    ilv_evt_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_s),
      .push_data ({cap_bx[s*ID_W +: ID_W], cap_trig[s*ID_W +: ID_W],
                   cap_smp[s*BANK_W +: BANK_W]}),
      .pop       (pop_s),
      .head      (heads[s]),
      .empty     (empty[s]),
      .full      (src_full[s])
    );
  end

  ilv_rr_pick #(.NSRC(NSRC)) u_pick (
    .req  (~empty),
    .last (grant),
    .pick (pick)
  );

  assign cur = heads[grant];

  // Word formatting
  logic [ID_W-1:0]    cur_bx, cur_trig;
  logic [BANK_W-1:0]  cur_bank;
  logic [OUT_W-2:0]   hdr_body;
  logic [LINE_W-2:0]  line_body;
  logic [LINE_W-1:0]  col_par;
  logic [SAMP_W-1:0]  line_smp;

  assign cur_bx   = cur[ENT_W-1 -: ID_W];
  assign cur_trig = cur[BANK_W +: ID_W];
  assign cur_bank = cur[BANK_W-1:0];
  assign hdr_body = {grant, 1'b1, HPAD'(0), cur_bx, cur_trig};

  always_comb begin
    line_smp  = cur_bank[chan_of(int'(idx), STRIDE, GROUPS) * SAMP_W +: SAMP_W];
    line_body = {grant, line_smp};
  end

  always_comb begin
    logic [LINE_W-2:0] b;
    col_par = '0;
    for (int c = 0; c < NCH; c++) begin
      b       = {grant, cur_bank[c*SAMP_W +: SAMP_W]};
      col_par = col_par ^ {^b, b};
    end
  end

  always_comb begin
    out_valid = (state != S_IDLE);
    case (state)
      S_HDR:   out_data = {^hdr_body, hdr_body};
      S_DATA:  out_data = OUT_W'({^line_body, line_body});
      S_TRL:   out_data = OUT_W'(col_par);
      default: out_data = '0;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      grant      <= SRC_W'(NSRC - 1);
      idx        <= '0;
      sep_second <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (|(~empty)) begin
          grant <= pick;
          state <= S_HDR;
        end
        S_HDR: if (fire) begin
          idx   <= '0;
          state <= S_DATA;
        end
        S_DATA: if (fire) begin
          if (idx == IDX_W'(NCH - 1)) state <= S_TRL;
          else idx <= idx + 1'b1;
        end
        S_TRL: if (fire) begin
          sep_second <= 1'b0;
          state      <= S_SEP;
        end
        S_SEP: if (fire) begin
          if (!sep_second) sep_second <= 1'b1;
          else if (|(~empty)) begin
            grant <= pick;
            state <= S_HDR;
          end else state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: an offered word is held under back-pressure
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R6: a header is only offered for a source that holds an event
  p_hdr_has_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && state == S_HDR) |-> !empty[grant]);
  // R3: every data line leaves with even parity
  p_line_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && state == S_DATA) |-> (^out_data == 1'b0));
  // R5: the word after an accepted trailer is a zero separator
  p_sep_after_trl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && state == S_TRL) |=> (out_valid && out_data == '0));
endmodule

// File: tb/ilv_frame_ser_tb.sv
module ilv_frame_ser_tb_top;
  localparam int NSRC = 8;
  localparam int NCH  = 32;
  localparam int SW   = 12;

  typedef struct packed {
    logic [2:0]  src;
    logic [11:0] bx;
    logic [11:0] trig;
    logic [7:0]  seed;
    logic        stall;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 12'h001, 12'h010, 8'd1, 1'b0},
    '{3'd1, 12'hFFF, 12'h000, 8'd2, 1'b1},
    '{3'd7, 12'h555, 12'hAAA, 8'd3, 1'b1},
    '{3'd4, 12'h000, 12'hFFF, 8'd4, 1'b0},
    '{3'd6, 12'h123, 12'h321, 8'd5, 1'b1},
    '{3'd3, 12'h800, 12'h001, 8'd6, 1'b0}
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NSRC-1:0]        cap_stb = '0;
  logic [NSRC*12-1:0]     cap_bx = '0;
  logic [NSRC*12-1:0]     cap_trig = '0;
  logic [NSRC*NCH*SW-1:0] cap_smp = '0;
  logic [NSRC-1:0]        src_full;
  logic                   out_valid;
  logic                   out_ready = 1'b0;
  logic [31:0]            out_data;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        have_held = 1'b0;
  logic [31:0] held_word = '0;

  always #5 clk = ~clk;

  ilv_frame_ser dut_i (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_bx(cap_bx),
    .cap_trig(cap_trig), .cap_smp(cap_smp), .src_full(src_full),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [11:0] smp_of(int seed, int c);
    return 12'((seed * 13 + c * 97 + c * c) % 4096);
  endfunction

  function automatic logic [31:0] exp_hdr(logic [2:0] s, logic [11:0] bx, logic [11:0] tr);
    logic [30:0] b;
    b = {s, 1'b1, 3'b000, bx, tr};
    return {^b, b};
  endfunction

  function automatic logic [31:0] exp_line(logic [2:0] s, logic [11:0] v);
    logic [14:0] b;
    b = {s, v};
    return {16'b0, ^b, b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_fields(int s, logic [11:0] bx, logic [11:0] tr, int seed);
    cap_bx[s*12 +: 12]   = bx;
    cap_trig[s*12 +: 12] = tr;
    for (int c = 0; c < NCH; c++) cap_smp[(s*NCH + c)*SW +: SW] = smp_of(seed, c);
  endtask

  task automatic strobe(logic [NSRC-1:0] m);
    cap_stb = m;
    @(posedge clk);
    #1 cap_stb = '0;
  endtask

  task automatic recv(output logic [31:0] w, input logic stall);
    logic got;
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall ? lfsr[0] : 1'b1;
      #1;
      if (out_valid || have_held) begin
        if (have_held) check("R8 hold", {31'b0, out_valid} ^ 32'h0 ^ ((out_data !== held_word) ? 32'hDEAD_0000 : 32'h0) ^ {31'b0, ~out_valid} , 32'h1 ^ {31'b0, ~out_valid});
        if (out_ready && out_valid) begin
          w = out_data; got = 1'b1; have_held = 1'b0;
        end else if (out_valid) begin
          held_word = out_data; have_held = 1'b1;
        end
      end
    end
  endtask

  task automatic check_frame(logic [2:0] s, logic [11:0] bx, logic [11:0] tr, int seed, logic stall);
    logic [31:0] w, e, col;
    col = '0;
    recv(w, stall);
    check("R1 header", w, exp_hdr(s, bx, tr));
    for (int j = 0; j < NCH; j++) begin
      int ch;
      ch = 4 * (j % 8) + j / 8;
      e  = exp_line(s, smp_of(seed, ch));
      col = col ^ e;
      recv(w, stall);
      check("R2 line order", w, e);
      check("R3 line parity", {31'b0, ^w}, 32'h0);
    end
    recv(w, stall);
    check("R4 trailer", w, col);
    recv(w, stall);
    check("R5 separator 1", w, 32'h0);
    recv(w, stall);
    check("R5 separator 2", w, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {31'b0, out_valid}, 32'h0);
    check("R9 reset full", {24'b0, src_full}, 32'h0);
    rst_n = 1'b1;

    // Table walk: one event per vector, frame compared word by word
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      load_fields(int'(VECS[v].src), VECS[v].bx, VECS[v].trig, int'(VECS[v].seed));
      strobe(8'(1) << VECS[v].src);
      check_frame(VECS[v].src, VECS[v].bx, VECS[v].trig, int'(VECS[v].seed), VECS[v].stall);
    end

    // R6: three sources loaded together after source 3 was served -> 5, 7, 2
    @(negedge clk);
    load_fields(2, 12'h0A2, 12'h0B2, 40);
    load_fields(5, 12'h0A5, 12'h0B5, 41);
    load_fields(7, 12'h0A7, 12'h0B7, 42);
    strobe(8'b1010_0100);
    check_frame(3'd5, 12'h0A5, 12'h0B5, 41, 1'b1);
    check_frame(3'd7, 12'h0A7, 12'h0B7, 42, 1'b0);
    check_frame(3'd2, 12'h0A2, 12'h0B2, 40, 1'b1);

    // R7: fill source 1 under full back-pressure, overflow strobe dropped
    @(negedge clk);
    out_ready = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      load_fields(1, 12'(k), 12'(k + 100), k + 20);
      strobe(8'b0000_0010);
    end
    @(negedge clk);
    check("R7 full after 16", {24'b0, src_full}, 32'h2);
    load_fields(1, 12'd99, 12'd99, 99);
    strobe(8'b0000_0010);
    @(negedge clk);
    check("R7 still full", {24'b0, src_full}, 32'h2);
    for (int k = 0; k < 16; k++)
      check_frame(3'd1, 12'(k), 12'(k + 100), k + 20, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 overflow dropped", {31'b0, out_valid}, 32'h0);
    check("R7 full cleared", {24'b0, src_full}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule